// File: doc/BRIEF.md
# Single-Wire Parity Byte Framer

This block moves one byte at a time across a single shared data wire. Two devices take turns driving the wire, and a pull-up holds it high when nobody drives it. On the send side, the block accepts a byte over a valid/ready stream. It then drives a low sync interval of one bit period and a short high marker. Next come the eight data bits, most significant first, and one even-parity bit. At the end of the frame it keeps the wire driven low. The next sync rising edge is therefore always visible, whichever value the last bit had.

On the receive side, the wire passes through a two-flop synchronizer. When the receiver is armed, it hunts for a low level, waiting at most a bounded number of bit periods. It then waits for the wire to return high, and that rising edge sets the time reference for the data bits. Each bit is sampled halfway through its period. A received parity bit that disagrees with the data still delivers the byte, marked as bad, and it advances a saturating error counter. A sticky error flag follows the counter, and a clear input resets both.

Sequencing of several bytes into a packet belongs to the surrounding controllers, and so does turning the wire around between the two devices. They arm the receiver, release the wire, and feed and drain the two streams.

Top module: `sw_byte_framer`

## Requirements
- R1: A byte is accepted on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low for the whole frame of 10 x BIT_CYCLES cycles, and the frame starts on the cycle after acceptance.
- R2: The first bit period of a frame (slot 0) drives the wire low (`line_oe`=1, `line_do`=0) for BIT_CYCLES cycles.
- R3: Slots 1 to 8 carry data bits 7 down to 0, each held for BIT_CYCLES cycles. For the first MARK_CYCLES cycles of slot 1, the wire is driven high whatever the value of bit 7, which guarantees a rising edge.
- R4: Slot 9 carries the parity bit, which equals the XOR of the eight data bits (even parity).
- R5: After slot 9, the wire stays driven low until a new byte is accepted or `line_release` is pulsed. Releasing it, and leaving reset, gives `line_oe`=0.
- R6: Once armed, the receiver waits for a low level on the synchronized wire and then for a high level. The rising edge that ends this wait starts slot 0 of the data.
- R7: Each received slot is sampled floor(BIT_CYCLES/2) cycles after its start. The first eight samples form `rx_data`, most significant first.
- R8: When the ninth sample differs from the XOR of the data, the byte is still delivered with `rx_perr`=1, `err_cnt` increments (saturating), and `err_flag` sets and stays set. A matching parity bit leaves both unchanged.
- R9: `err_clr` sets `err_cnt` to 0 and `err_flag` to 0 on the next cycle, and it wins over an increment in the same cycle.
- R10: `rx_valid`, `rx_data` and `rx_perr` hold steady until `rx_ready` is high. While a byte waits, the receiver does not hunt, so a byte is lost unless it is taken before the next sync edge begins.
- R11: With `rx_arm` low, the receiver ignores the wire: no byte is delivered and the error state is unchanged. Dropping `rx_arm` while hunting abandons the hunt; dropping it mid-byte does not.
- R12: If the wire stays high for HUNT_PERIODS x BIT_CYCLES cycles while hunting, the receiver skips the low wait and starts reading. On an idle high wire this yields 0xFF with a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Byte to send is valid |
| tx_ready | output | 1 | Framer can accept a byte |
| tx_data | input | DATA_W | Byte to send |
| line_release | input | 1 | Stop driving the wire after a frame |
| line_oe | output | 1 | Drive enable for the wire |
| line_do | output | 1 | Value driven when enabled |
| line_di | input | 1 | Raw wire level (asynchronous) |
| rx_arm | input | 1 | Allow the receiver to hunt for a frame |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W | Received byte |
| rx_perr | output | 1 | Parity mismatch on this byte |
| err_clr | input | 1 | Clear error count and flag |
| err_cnt | output | ERR_W | Saturating parity error count |
| err_flag | output | 1 | Sticky parity error indicator |

## Verification
The bench drives bytes whose most significant bit is 0. A framer without the high marker would then give no rising edge, and the receiver would slip a whole slot. It also sends back-to-back frames that end on parity 1 and on parity 0, which exposes a sender that failed to park the wire low. Frames with a deliberately wrong parity bit must arrive intact but flagged, and must move the counter, so a design that dropped the byte or missed the mismatch is caught. The bench also covers an idle high wire, which must end the hunt by timeout rather than hang; a stalled consumer, whose byte must not change; and a disarmed receiver, which must deliver nothing.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SEND,
    TX_PARK
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_HUNT,
    RX_WAIT,
    RX_BITS,
    RX_DONE
  } rx_state_e;
endpackage

// File: rtl/swf_sync.sv
module swf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= STAGES'({chain, d});
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swf_tx.sv
module swf_tx
  import swf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int MARK_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              release_i,
  output logic              drv_en,
  output logic              drv_val
);
  localparam int CNT_W  = $clog2(BIT_CYCLES);
  localparam int SLOT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CNT_MARK = CNT_W'(MARK_CYCLES);
  localparam logic [SLOT_W-1:0] SLOT_MSB = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_PAR = SLOT_W'(DATA_W + 1);

  tx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] shreg;
  logic              par;
  logic              take;
  logic              slot_end;

  assign in_ready = (st != TX_SEND);
  assign take     = in_valid && in_ready;
  assign slot_end = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      cnt   <= '0;
      slot  <= '0;
      shreg <= '0;
      par   <= 1'b0;
    end else begin
      unique case (st)
        TX_IDLE, TX_PARK: begin
          if (take) begin
            st    <= TX_SEND;
            cnt   <= '0;
            slot  <= '0;
            shreg <= in_data;
            par   <= ^in_data;
          end else if (release_i) begin
            st <= TX_IDLE;
          end
        end
        TX_SEND: begin
          if (slot_end) begin
            cnt <= '0;
            if (slot == SLOT_PAR) begin
              st <= TX_PARK;
            end else begin
              slot <= slot + 1'b1;
              if (slot != '0) shreg <= {shreg[DATA_W-2:0], 1'b0};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // Slot 0 low, slot 1 opens with a forced-high marker, data MSB first, parity last.
  always_comb begin
    drv_en  = 1'b1;
    drv_val = 1'b0;
    unique case (st)
      TX_IDLE: begin
        drv_en  = 1'b0;
        drv_val = 1'b1;
      end
      TX_PARK: drv_val = 1'b0;
      TX_SEND: begin
        if (slot == SLOT_PAR)                     drv_val = par;
        else if (slot == SLOT_MSB && cnt < CNT_MARK) drv_val = 1'b1;
        else if (slot != '0)                      drv_val = shreg[DATA_W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/swf_rx.sv
module swf_rx
  import swf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int BIT_CYCLES   = 16,
  parameter int HUNT_PERIODS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              arm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              perr_evt
);
  localparam int CNT_W       = $clog2(BIT_CYCLES);
  localparam int SLOT_W      = $clog2(DATA_W + 1);
  localparam int HUNT_CYCLES = HUNT_PERIODS * BIT_CYCLES;
  localparam int HUNT_W      = $clog2(HUNT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BIT_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CNT_MID   = CNT_W'(BIT_CYCLES / 2);
  localparam logic [SLOT_W-1:0] SLOT_PAR  = SLOT_W'(DATA_W);
  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(HUNT_CYCLES - 1);

  rx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;
  logic [HUNT_W-1:0] hcnt;
  logic [DATA_W-1:0] shreg;
  logic              calc;
  logic              perr;
  logic              mid;

  assign mid = (cnt == CNT_MID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      slot     <= '0;
      hcnt     <= '0;
      shreg    <= '0;
      calc     <= 1'b0;
      perr     <= 1'b0;
      perr_evt <= 1'b0;
    end else begin
      perr_evt <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (arm) begin
            st   <= RX_HUNT;
            hcnt <= '0;
          end
        end
        RX_HUNT: begin
          if (!arm)                               st <= RX_IDLE;
          else if (!line_s || hcnt == HUNT_LAST)  st <= RX_WAIT;
          else                                    hcnt <= hcnt + 1'b1;
        end
        RX_WAIT: begin
          if (!arm) begin
            st <= RX_IDLE;
          end else if (line_s) begin
            st   <= RX_BITS;
            cnt  <= '0;
            slot <= '0;
            calc <= 1'b0;
          end
        end
        RX_BITS: begin
          cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
          if (cnt == CNT_LAST) slot <= slot + 1'b1;
          if (mid) begin
            if (slot == SLOT_PAR) begin
              st       <= RX_DONE;
              perr     <= (line_s != calc);
              perr_evt <= (line_s != calc);
            end else begin
              shreg <= {shreg[DATA_W-2:0], line_s};
              calc  <= calc ^ line_s;
            end
          end
        end
        RX_DONE: begin
          if (out_ready) begin
            st   <= arm ? RX_HUNT : RX_IDLE;
            hcnt <= '0;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign out_valid = (st == RX_DONE);
  assign out_data  = shreg;
  assign out_perr  = perr;
endmodule

// File: rtl/swf_errcnt.sv
module swf_errcnt #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic [ERR_W-1:0] count,
  output logic             flag
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (clr) begin
      count <= '0;
      flag  <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sw_byte_framer.sv
module sw_byte_framer #(
  parameter int DATA_W       = 8,
  parameter int BIT_CYCLES   = 16,
  parameter int MARK_CYCLES  = 2,
  parameter int HUNT_PERIODS = 5,
  parameter int SYNC_STAGES  = 2,
  parameter int ERR_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              line_release,
  output logic              line_oe,
  output logic              line_do,
  input  logic              line_di,
  input  logic              rx_arm,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  input  logic              err_clr,
  output logic [ERR_W-1:0]  err_cnt,
  output logic              err_flag
);
  logic line_s;
  logic perr_evt;

  swf_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_di),
    .q    (line_s)
  );

  swf_tx #(
    .DATA_W     (DATA_W),
    .BIT_CYCLES (BIT_CYCLES),
    .MARK_CYCLES(MARK_CYCLES)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .release_i(line_release),
    .drv_en   (line_oe),
    .drv_val  (line_do)
  );

  swf_rx #(
    .DATA_W      (DATA_W),
    .BIT_CYCLES  (BIT_CYCLES),
    .HUNT_PERIODS(HUNT_PERIODS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .arm      (rx_arm),
    .out_valid(rx_valid),
    .out_ready(rx_ready),
    .out_data (rx_data),
    .out_perr (rx_perr),
    .perr_evt (perr_evt)
  );

  swf_errcnt #(
    .ERR_W(ERR_W)
  ) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (perr_evt),
    .clr  (err_clr),
    .count(err_cnt),
    .flag (err_flag)
  );
endmodule

// File: rtl/swf_chk.sv
module swf_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              line_oe,
  input logic              line_do,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_perr,
  input logic              err_clr,
  input logic [ERR_W-1:0]  err_cnt,
  input logic              err_flag
);
  // R1
  accept_opens_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (line_oe && !line_do && !tx_ready));

  // R5
  busy_drives_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> line_oe);

  // R10
  rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_perr)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (err_cnt == '0 && !err_flag));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R8
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_cnt >= $past(err_cnt)));
endmodule

bind sw_byte_framer swf_chk #(
  .DATA_W(DATA_W),
  .ERR_W (ERR_W)
) u_swf_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .line_oe (line_oe),
  .line_do (line_do),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .rx_data (rx_data),
  .rx_perr (rx_perr),
  .err_clr (err_clr),
  .err_cnt (err_cnt),
  .err_flag(err_flag)
);

// File: tb/sw_byte_framer_tb_top.sv
module sw_byte_framer_tb_top;
  localparam int BIT  = 16;
  localparam int MARK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       line_release = 1'b0;
  logic       line_oe, line_do, line_di;
  logic       rx_arm = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic [7:0] rx_data;
  logic       rx_perr;
  logic       err_clr = 1'b0;
  logic [3:0] err_cnt;
  logic       err_flag;
  logic       bench_oe = 1'b0;
  logic       bench_do = 1'b1;

  // Pull-up wire shared by the framer and a bench-side remote sender.
  assign line_di = line_oe ? line_do : (bench_oe ? bench_do : 1'b1);

  int n_run = 0;
  int n_fail = 0;
  int rx_seen = 0;
  logic [8:0] exp_q[$];
  logic [8:0] mon_e;

  sw_byte_framer dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .line_release(line_release), .line_oe(line_oe), .line_do(line_do), .line_di(line_di),
    .rx_arm(rx_arm), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr),
    .err_clr(err_clr), .err_cnt(err_cnt), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Scoreboard monitor: pops one expected {perr,data} per handshake.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rx_valid && rx_ready) begin
      rx_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected byte", {23'd0, rx_perr, rx_data}, 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({rx_perr, rx_data} == mon_e, "R7 received byte/flag", {23'd0, rx_perr, rx_data}, {23'd0, mon_e});
      end
    end
  end

  // Sends one byte and checks the wire mid-slot (R1..R5).
  task automatic send_watch(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(line_oe && !line_do && !tx_ready, "R1 frame starts after accept", {line_oe, line_do, tx_ready}, 3'b100);
    for (int j = 0; j < 10 * BIT; j++) begin
      int s;
      int c;
      logic e;
      if (j > 0) @(negedge clk);
      s = j / BIT;
      c = j % BIT;
      if (s == 1 && c == 0)
        chk(line_oe && line_do, "R3 edge marker high", {line_oe, line_do}, 2'b11);
      if (c == BIT / 2) begin
        e = (s == 0) ? 1'b0 : (s == 9) ? ^d : d[8-s];
        if (s == 0)      chk(line_oe && line_do == e && !tx_ready, "R2 sync low", line_do, e);
        else if (s == 9) chk(line_oe && line_do == e && !tx_ready, "R4 even parity bit", line_do, e);
        else             chk(line_oe && line_do == e && !tx_ready, "R3 data bit MSB first", line_do, e);
      end
    end
    @(negedge clk);
    chk(line_oe && !line_do && tx_ready, "R5 parked low after frame", {line_oe, line_do, tx_ready}, 3'b101);
  endtask

  // Remote sender on the bench side of the wire, with a chosen parity bit.
  task automatic bench_frame(input logic [7:0] d, input logic pbit);
    for (int j = 0; j < 10 * BIT; j++) begin
      int s;
      int c;
      @(negedge clk);
      s = j / BIT;
      c = j % BIT;
      bench_do = (s == 0) ? 1'b0 : (s == 9) ? pbit : (s == 1 && c < MARK) ? 1'b1 : d[8-s];
    end
    @(negedge clk);
    bench_do = 1'b0;
  endtask

  task automatic wait_empty(input int maxc, input string tag);
    for (int k = 0; k < maxc && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] seq [6];
    int seen0;
    logic [3:0] e0;
    seq = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h80, 8'h01};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_oe, "R5 wire released after reset", line_oe, 0);
    chk(tx_ready, "R1 ready after reset", tx_ready, 1);
    chk(!rx_valid, "R10 no byte after reset", rx_valid, 0);
    chk(err_cnt == 0 && !err_flag, "R9 error state after reset", {err_flag, err_cnt}, 0);

    // Loopback, back-to-back frames (R6, R7)
    rx_arm = 1'b1;
    foreach (seq[i]) begin
      exp_q.push_back({1'b0, seq[i]});
      send_watch(seq[i]);
    end
    wait_empty(4 * BIT, "R6 loopback bytes delivered");
    chk(err_cnt == 0, "R8 no error on good parity", err_cnt, 0);

    // Remote sender with bad parity (R8)
    @(negedge clk);
    rx_arm = 1'b0;
    @(negedge clk);
    line_release = 1'b1;
    bench_oe = 1'b1;
    bench_do = 1'b1;
    @(negedge clk);
    line_release = 1'b0;
    repeat (4) @(negedge clk);
    chk(!line_oe, "R5 release drops drive", line_oe, 0);
    rx_arm = 1'b1;
    exp_q.push_back({1'b1, 8'h5A});
    bench_frame(8'h5A, ~^8'h5A);
    wait_empty(4 * BIT, "R8 bad byte delivered");
    repeat (2) @(negedge clk);
    chk(err_cnt == 1 && err_flag, "R8 first mismatch counted", {err_flag, err_cnt}, 5'h11);
    exp_q.push_back({1'b1, 8'hC7});
    bench_frame(8'hC7, ~^8'hC7);
    wait_empty(4 * BIT, "R8 second bad byte delivered");
    repeat (2) @(negedge clk);
    chk(err_cnt == 2, "R8 second mismatch counted", err_cnt, 2);
    exp_q.push_back({1'b0, 8'h96});
    bench_frame(8'h96, ^8'h96);
    wait_empty(4 * BIT, "R7 good remote byte delivered");
    repeat (2) @(negedge clk);
    chk(err_cnt == 2 && err_flag, "R8 match leaves count", {err_flag, err_cnt}, 5'h12);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_cnt == 0 && !err_flag, "R9 clear", {err_flag, err_cnt}, 0);

    // Back-pressure (R10)
    rx_arm = 1'b0;
    @(negedge clk);
    bench_oe = 1'b0;
    repeat (4) @(negedge clk);
    rx_arm = 1'b1;
    rx_ready = 1'b0;
    exp_q.push_back({1'b0, 8'h69});
    send_watch(8'h69);
    for (int k = 0; k < 4; k++) begin
      repeat (5) @(negedge clk);
      chk(rx_valid && rx_data == 8'h69 && !rx_perr, "R10 byte held while stalled", {rx_valid, rx_data}, 9'h169);
    end
    rx_ready = 1'b1;
    wait_empty(4, "R10 byte taken after stall");

    // Disarmed receiver ignores the wire (R11)
    rx_arm = 1'b0;
    seen0 = rx_seen;
    e0 = err_cnt;
    send_watch(8'hC3);
    repeat (2 * BIT) @(negedge clk);
    chk(rx_seen == seen0 && !rx_valid, "R11 disarmed receiver ignores frame", rx_seen - seen0, 0);
    chk(err_cnt == e0, "R11 error count untouched", err_cnt, e0);

    // Hunt timeout on an idle high wire (R12)
    line_release = 1'b1;
    @(negedge clk);
    line_release = 1'b0;
    repeat (4) @(negedge clk);
    rx_arm = 1'b1;
    exp_q.push_back({1'b1, 8'hFF});
    repeat (4 * BIT) @(negedge clk);
    chk(exp_q.size() == 1 && !rx_valid, "R6 hunt still waiting for low", rx_valid, 0);
    wait_empty(20 * BIT, "R12 timeout read delivered");
    rx_arm = 1'b0;
    repeat (2) @(negedge clk);
    chk(err_cnt == 1 && err_flag, "R12 timeout read flags parity", {err_flag, err_cnt}, 5'h11);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule